// File: doc/BRIEF.md
# Dual-Mode External Bus Arbiter

This unit decides who drives a shared external memory bus. Three active-low handshake lines connect it to other bus users: request, grant and busy. A mode input sets its role. In slave mode the unit owns the bus by default and gives it up when another device requests it. In master mode the unit must ask for the bus and wait for a grant before the core may run an external access.

The core presents one external access at a time, marked as a program or a data access, and raises a lock for an indivisible read-modify-write sequence. The arbiter returns a go signal when the access may run this cycle. It also returns a wait signal and an interrupt-hold signal while the access is stalled. Internal-only work is never stalled. The unit drives the bus drive enable that controls the tri-state buffers, and a status bit that shows the synchronized grant level. Every handshake input passes through a two-stage synchronizer before the state machine uses it.

Top module: `xbus_arbiter`

## Requirements
- R1: While reset is low, and in the first sample after reset, the bus drive enable is 0 and all three handshake outputs are high (deasserted). The grant status bit reads 0 during reset even when the grant input is low.
- R2: Handshake inputs are active low, and the arbiter sees them two clock edges after they change. In slave mode, with the bus owned, a request input driven low before edge k produces grant-out low, and turns the drive enable off, only after edge k+2.
- R3: In slave mode, while grant-out is low, the drive enable is 0 and busy-out is high.
- R4: In slave mode, grant-out returns high two edges after the request input returns high. The bus is taken back (drive enable 1) only on the third edge after the busy input is seen high. It stays released while busy is low.
- R5: While the read-modify-write lock is high and the bus is owned, the arbiter never gives up the bus. In slave mode, grant-out stays high and a pending request does not stall the locked accesses. In master mode, the bus is kept and accesses go on even if grant is withdrawn. In slave mode, the grant follows two edges after the lock drops.
- R6: In slave mode, an external access requested while the bus is not available (request pending, or bus released) gets go=0, wait=1 and interrupt-hold=1. With no external access requested, wait and interrupt-hold are 0.
- R7: In master mode, a pending external access asserts request-out (low) and holds the core in wait. The bus is driven, and go is given, only on the third edge after grant is seen low and busy is seen high.
- R8: In master mode, with the request-hold input set, request-out stays low even with no access pending, and program accesses run on every cycle. Request-out goes high one edge after hold is cleared with no access pending.
- R9: In master mode, with grant held low, back-to-back data accesses keep request-out low and run every cycle. Back-to-back program accesses toggle request-out: over 12 cycles, 4 accesses run and request-out is high in 4 cycles.
- R10: In master mode, after grant is withdrawn the access already seen runs to completion. No new access starts once the withdrawal is seen (two edges). The drive enable drops on the following edge.
- R11: The grant status bit equals the grant input level (1 = grant low) two edges after the input changes.
- R12: Request-out is only ever low in master mode, and grant-out is only ever low in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_mode_i | input | 1 | 1 = requester role, 0 = default-owner role |
| req_hold_i | input | 1 | Keep request-out asserted (master mode) |
| ext_acc_req_i | input | 1 | Core wants an external access this cycle |
| acc_is_prog_i | input | 1 | 1 = program-space access, 0 = data access |
| rmw_lock_i | input | 1 | Indivisible read-modify-write in progress |
| bus_req_in_n_i | input | 1 | Request from another device, active low (slave mode) |
| bus_gnt_in_n_i | input | 1 | Grant from the bus owner, active low (master mode) |
| bus_busy_in_n_i | input | 1 | Busy line, active low, low while another device drives |
| bus_req_out_n_o | output | 1 | Request to the bus owner, active low |
| bus_gnt_out_n_o | output | 1 | Grant to the requesting device, active low |
| bus_busy_out_n_o | output | 1 | Busy driven while this unit owns the bus, active low |
| bus_drive_en_o | output | 1 | Enables the address, data and control drivers |
| acc_go_o | output | 1 | The requested external access runs this cycle |
| core_wait_o | output | 1 | Wait state for a stalled external access |
| irq_hold_o | output | 1 | Holds off interrupts while the core is stalled |
| gnt_status_o | output | 1 | Synchronized grant level, 1 = asserted |

## Verification
The bench counts clock edges through the synchronizer. A design with one stage too few or one too many grants, or reclaims, a cycle early or late. The bench holds busy low after a request ends, so a design that ignores busy grabs the bus while another device still drives it. It raises a request and withdraws grant inside a read-modify-write lock, so a design that hands over there breaks the indivisible sequence. It runs 12-cycle windows of program and data accesses, with and without the hold bit. A design that mixes up the two toggling rules shows the wrong number of accesses or request-high cycles.

// File: rtl/xbus_arb_pkg.sv
package xbus_arb_pkg;

    typedef enum logic [2:0] {
        ST_RELEASED   = 3'd0,
        ST_IDLE_OWNED = 3'd1,
        ST_REQUESTING = 3'd2,
        ST_OWNED      = 3'd3,
        ST_RMW_LOCKED = 3'd4
    } arb_state_e;

    typedef struct packed {
        arb_state_e state;
    } arb_regs_t;

    function automatic logic state_owns(input arb_state_e s);
        return (s == ST_IDLE_OWNED) || (s == ST_OWNED) || (s == ST_RMW_LOCKED);
    endfunction

endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb stage_d[0] = async_i;

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_comb stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xbus_arb_pins.sv
module xbus_arb_pins
    import xbus_arb_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  arb_state_e state_i,
    input  logic       master_i,
    input  logic       hold_i,
    input  logic       ext_req_i,
    input  logic       rmw_i,
    input  logic       req_s_i,
    input  logic       gnt_s_i,
    output logic       drive_en_o,
    output logic       busy_out_n_o,
    output logic       req_out_n_o,
    output logic       gnt_out_n_o,
    output logic       acc_go_o,
    output logic       core_wait_o,
    output logic       irq_hold_o
);
    logic owns;
    logic req_active;
    logic go;

    always_comb begin
        owns       = state_owns(state_i);
        req_active = hold_i || (state_i == ST_REQUESTING) ||
                     (state_i == ST_OWNED) || (state_i == ST_RMW_LOCKED);
        case (state_i)
            ST_IDLE_OWNED: go = ext_req_i && (!req_s_i || rmw_i);
            ST_RMW_LOCKED: go = ext_req_i;
            ST_OWNED:      go = ext_req_i && (gnt_s_i || rmw_i);
            default:       go = 1'b0;
        endcase
    end

    assign drive_en_o   = owns;
    assign busy_out_n_o = !owns;
    assign req_out_n_o  = !(master_i && req_active);
    assign gnt_out_n_o  = !(!master_i && (state_i == ST_RELEASED) && req_s_i);
    assign acc_go_o     = go;
    assign core_wait_o  = ext_req_i && !go;
    assign irq_hold_o   = ext_req_i && !go;

    // R6: an external access with no bus in hand must stall
    p_stall_when_unowned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_req_i && !drive_en_o) |-> core_wait_o);

    // R7: an access only runs on a driven bus
    p_go_needs_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_go_o |-> drive_en_o);

    // R3: a granted bus is never driven
    p_released_tristate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gnt_out_n_o |-> (!drive_en_o && busy_out_n_o));
endmodule

// File: rtl/xbus_arb_fsm.sv
module xbus_arb_fsm
    import xbus_arb_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       master_i,
    input  logic       hold_i,
    input  logic       ext_req_i,
    input  logic       prog_i,
    input  logic       rmw_i,
    input  logic       acc_go_i,
    input  logic       req_s_i,
    input  logic       gnt_s_i,
    input  logic       busy_s_i,
    output arb_state_e state_o
);
    arb_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_RELEASED: begin
                if (!master_i) begin
                    if (!req_s_i && !busy_s_i) regs_d.state = ST_IDLE_OWNED;
                end else if (ext_req_i || hold_i) begin
                    regs_d.state = ST_REQUESTING;
                end
            end
            ST_IDLE_OWNED: begin
                if (rmw_i)                  regs_d.state = ST_RMW_LOCKED;
                else if (master_i || req_s_i) regs_d.state = ST_RELEASED;
            end
            ST_REQUESTING: begin
                if (!master_i)                  regs_d.state = ST_RELEASED;
                else if (gnt_s_i && !busy_s_i)  regs_d.state = ST_OWNED;
                else if (!ext_req_i && !hold_i) regs_d.state = ST_RELEASED;
            end
            ST_OWNED: begin
                if (rmw_i)                               regs_d.state = ST_RMW_LOCKED;
                else if (!master_i || !gnt_s_i)          regs_d.state = ST_RELEASED;
                else if (acc_go_i && prog_i && !hold_i)  regs_d.state = ST_RELEASED;
                else if (!ext_req_i && !hold_i)          regs_d.state = ST_RELEASED;
            end
            ST_RMW_LOCKED: begin
                if (!rmw_i) regs_d.state = master_i ? ST_OWNED : ST_IDLE_OWNED;
            end
            default: regs_d.state = ST_RELEASED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '{state: ST_RELEASED};
        else         regs_q <= regs_d;
    end

    assign state_o = regs_q.state;

    // R5: once owned under lock, ownership survives the next edge
    p_rmw_keeps_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rmw_i && state_owns(regs_q.state)) |=> state_owns(regs_q.state));
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
    import xbus_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic master_mode_i,
    input  logic req_hold_i,
    input  logic ext_acc_req_i,
    input  logic acc_is_prog_i,
    input  logic rmw_lock_i,
    input  logic bus_req_in_n_i,
    input  logic bus_gnt_in_n_i,
    input  logic bus_busy_in_n_i,
    output logic bus_req_out_n_o,
    output logic bus_gnt_out_n_o,
    output logic bus_busy_out_n_o,
    output logic bus_drive_en_o,
    output logic acc_go_o,
    output logic core_wait_o,
    output logic irq_hold_o,
    output logic gnt_status_o
);
    localparam int N_HS    = 3;
    localparam int IDX_REQ = 0;
    localparam int IDX_GNT = 1;
    localparam int IDX_BSY = 2;

    logic [N_HS-1:0] hs_raw, hs_sync;
    arb_state_e      state;
    logic            go;

    assign hs_raw[IDX_REQ] = !bus_req_in_n_i;
    assign hs_raw[IDX_GNT] = !bus_gnt_in_n_i;
    assign hs_raw[IDX_BSY] = !bus_busy_in_n_i;

    xbus_sync #(.WIDTH(N_HS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (hs_raw),
        .sync_o  (hs_sync)
    );

    xbus_arb_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .master_i  (master_mode_i),
        .hold_i    (req_hold_i),
        .ext_req_i (ext_acc_req_i),
        .prog_i    (acc_is_prog_i),
        .rmw_i     (rmw_lock_i),
        .acc_go_i  (go),
        .req_s_i   (hs_sync[IDX_REQ]),
        .gnt_s_i   (hs_sync[IDX_GNT]),
        .busy_s_i  (hs_sync[IDX_BSY]),
        .state_o   (state)
    );

    xbus_arb_pins u_pins (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .state_i      (state),
        .master_i     (master_mode_i),
        .hold_i       (req_hold_i),
        .ext_req_i    (ext_acc_req_i),
        .rmw_i        (rmw_lock_i),
        .req_s_i      (hs_sync[IDX_REQ]),
        .gnt_s_i      (hs_sync[IDX_GNT]),
        .drive_en_o   (bus_drive_en_o),
        .busy_out_n_o (bus_busy_out_n_o),
        .req_out_n_o  (bus_req_out_n_o),
        .gnt_out_n_o  (bus_gnt_out_n_o),
        .acc_go_o     (go),
        .core_wait_o  (core_wait_o),
        .irq_hold_o   (irq_hold_o)
    );

    assign acc_go_o     = go;
    assign gnt_status_o = hs_sync[IDX_GNT];

    // R4: slave reclaim never overlaps an outstanding grant
    p_reclaim_after_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!master_mode_i && $rose(bus_drive_en_o)) |-> $past(bus_gnt_out_n_o));

    // R7: master ownership is always preceded by an asserted request
    p_own_after_request_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (master_mode_i && $rose(bus_drive_en_o)) |-> !$past(bus_req_out_n_o));

    // R11: status shows the grant input two edges back
    p_status_lag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_status_o |-> !$past(bus_gnt_in_n_i, 2));
endmodule

// File: tb/sim_xbus_arbiter.sv
module sim_xbus_arbiter;
    logic clk = 1'b0;
    logic rst_n;
    logic master, hold, ext_req, prog, rmw;
    logic req_in_n, gnt_in_n, busy_in_n;
    logic req_out_n, gnt_out_n, busy_out_n, drive_en, acc_go, core_wait, irq_hold, gnt_status;

    int n_chk  = 0;
    int n_fail = 0;
    int viol_r3  = 0;
    int viol_r12 = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xbus_arbiter u0 (
        .clk_i(clk), .rst_ni(rst_n), .master_mode_i(master), .req_hold_i(hold),
        .ext_acc_req_i(ext_req), .acc_is_prog_i(prog), .rmw_lock_i(rmw),
        .bus_req_in_n_i(req_in_n), .bus_gnt_in_n_i(gnt_in_n), .bus_busy_in_n_i(busy_in_n),
        .bus_req_out_n_o(req_out_n), .bus_gnt_out_n_o(gnt_out_n),
        .bus_busy_out_n_o(busy_out_n), .bus_drive_en_o(drive_en), .acc_go_o(acc_go),
        .core_wait_o(core_wait), .irq_hold_o(irq_hold), .gnt_status_o(gnt_status)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    // R3 / R12 invariants sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (!master && !gnt_out_n && drive_en) viol_r3++;
            if (!master && !req_out_n) viol_r12++;
            if (master && !gnt_out_n)  viol_r12++;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int acc_cnt, off_cnt;
        rst_n = 0; master = 0; hold = 0; ext_req = 0; prog = 0; rmw = 0;
        req_in_n = 1; gnt_in_n = 0; busy_in_n = 1;
        step(3);
        chk("R1 drive in reset", drive_en, 0);
        chk("R1 req_out in reset", req_out_n, 1);
        chk("R1 gnt_out in reset", gnt_out_n, 1);
        chk("R1 busy_out in reset", busy_out_n, 1);
        chk("R11 status ignored in reset", gnt_status, 0);
        rst_n = 1;
        step(1);
        chk("R1 slave owns after reset", drive_en, 1);
        chk("R11 status lag 1", gnt_status, 0);
        step(1);
        chk("R11 status lag 2", gnt_status, 1);
        gnt_in_n = 1;
        step(1);
        chk("R11 status hold", gnt_status, 1);
        step(1);
        chk("R11 status drop", gnt_status, 0);

        // slave handover
        req_in_n = 0;
        step(1);
        chk("R2 no grant after 1 edge", gnt_out_n, 1);
        step(1);
        chk("R2 no grant after 2 edges", gnt_out_n, 1);
        chk("R2 still driving", drive_en, 1);
        ext_req = 1; #1;
        chk("R6 pending req stalls go", acc_go, 0);
        chk("R6 pending req wait", core_wait, 1);
        chk("R6 pending req irq hold", irq_hold, 1);
        step(1);
        chk("R2 grant after 3 edges", gnt_out_n, 0);
        chk("R3 tristate when granted", drive_en, 0);
        chk("R3 busy released", busy_out_n, 1);
        chk("R6 released wait", core_wait, 1);
        ext_req = 0; #1;
        chk("R6 internal work no wait", core_wait, 0);
        chk("R6 internal work no irq hold", irq_hold, 0);

        // slave reclaim
        req_in_n = 1; busy_in_n = 0;
        step(1);
        chk("R4 grant held 1 edge", gnt_out_n, 0);
        step(1);
        chk("R4 grant dropped", gnt_out_n, 1);
        for (int i = 0; i < 3; i++) begin
            step(1);
            chk("R4 stays released while busy", drive_en, 0);
        end
        busy_in_n = 1;
        step(2);
        chk("R4 not yet reclaimed", drive_en, 0);
        step(1);
        chk("R4 reclaimed after busy high", drive_en, 1);

        // slave read-modify-write
        rmw = 1; ext_req = 1;
        step(1);
        req_in_n = 0;
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R5 no grant in lock", gnt_out_n, 1);
            chk("R5 bus kept in lock", drive_en, 1);
            chk("R5 locked access runs", acc_go, 1);
        end
        rmw = 0; ext_req = 0;
        step(1);
        chk("R5 grant not yet", gnt_out_n, 1);
        step(1);
        chk("R5 grant after lock", gnt_out_n, 0);
        req_in_n = 1;
        step(4);
        chk("R4 reclaim after rmw handover", drive_en, 1);

        // master mode
        rst_n = 0; master = 1; gnt_in_n = 1; busy_in_n = 1;
        step(2);
        rst_n = 1;
        step(2);
        chk("R7 master idle no drive", drive_en, 0);
        chk("R7 master idle no request", req_out_n, 1);
        ext_req = 1; prog = 0;
        step(1);
        chk("R7 request asserted", req_out_n, 0);
        chk("R7 no drive before grant", drive_en, 0);
        chk("R7 wait before grant", core_wait, 1);
        gnt_in_n = 0; busy_in_n = 0;
        step(4);
        chk("R7 granted but busy", drive_en, 0);
        busy_in_n = 1;
        step(2);
        chk("R7 busy seen 2 edges", drive_en, 0);
        step(1);
        chk("R7 owned", drive_en, 1);
        chk("R7 go", acc_go, 1);
        chk("R7 busy out", busy_out_n, 0);
        chk("R7 no wait", core_wait, 0);

        for (int i = 0; i < 6; i++) begin
            step(1);
            chk("R9 data keeps request", req_out_n, 0);
            chk("R9 data every cycle", acc_go, 1);
        end

        // grant withdrawn
        gnt_in_n = 1;
        step(1);
        chk("R10 in-flight access runs", acc_go, 1);
        step(1);
        chk("R10 no new access", acc_go, 0);
        chk("R10 wait", core_wait, 1);
        chk("R10 still driving", drive_en, 1);
        step(1);
        chk("R10 released", drive_en, 0);
        step(1);
        chk("R10 re-requesting", req_out_n, 0);
        chk("R10 not driving", drive_en, 0);

        // program toggling with grant held
        gnt_in_n = 0; prog = 1;
        step(3);
        acc_cnt = 0; off_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            acc_cnt += int'(acc_go);
            off_cnt += int'(req_out_n);
            step(1);
        end
        chk("R9 program accesses per 12", acc_cnt, 4);
        chk("R9 program request-high per 12", off_cnt, 4);

        hold = 1;
        step(3);
        acc_cnt = 0; off_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            acc_cnt += int'(acc_go);
            off_cnt += int'(req_out_n);
            step(1);
        end
        chk("R8 hold program accesses", acc_cnt, 12);
        chk("R8 hold request-high", off_cnt, 0);
        ext_req = 0; #1;
        chk("R8 hold with nothing pending", req_out_n, 0);
        step(1);
        chk("R8 hold keeps request", req_out_n, 0);
        hold = 0;
        step(1);
        chk("R8 request drops after hold", req_out_n, 1);

        // master read-modify-write
        prog = 0; ext_req = 1;
        step(2);
        chk("R5 master owned", drive_en, 1);
        rmw = 1;
        step(1);
        gnt_in_n = 1;
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk("R5 master keeps bus in lock", drive_en, 1);
            chk("R5 master access in lock", acc_go, 1);
        end
        rmw = 0;
        step(1);
        chk("R10 no access after lock", acc_go, 0);
        chk("R10 drive until release", drive_en, 1);
        step(1);
        chk("R10 released after lock", drive_en, 0);

        chk("R3 no drive while granted", viol_r3, 0);
        chk("R12 pin roles by mode", viol_r12, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule